// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block turns one request for a multi-register memory transfer into a series of single-word transfers, one per accepted memory cycle. A request carries a base address, a bitmap choosing any of sixteen registers, a direction/timing mode, a load-or-store select and a base-update flag. The sequencer walks the chosen registers from the lowest index to the highest. For each one it presents a word-aligned address, the register index and a write strobe, and it waits for memory to signal ready.

The addressing covers four variants. Addresses either climb or fall, and the step is applied either before or after each word. Whatever the variant, the lowest-numbered register always lands at the lowest address. When the last word is accepted, the block pulses done for one cycle. At the same time it presents the updated base value, with a write enable that is raised only if base update was requested. A request with an empty bitmap finishes at once, with no transfer.

Top module: `lsm_addr_seq`

## Requirements
- R1: After reset the block is idle: busy_o, mem_req_o, done_o and base_we_o are all 0.
- R2: For n selected registers, the first address presented is derived from the mode. Mode 0 (climb, step after) uses base. Mode 1 (climb, step before) uses base+4. Mode 2 (fall, step after) uses base-4n+4. Mode 3 (fall, step before) uses base-4n. The start strobe is sampled on a clock edge while idle, and the first request appears in the following cycle.
- R3: Each accepted word advances the address by exactly 4 (modulo 2^32).
- R4: A transfer is accepted only in a cycle with mem_req_o and mem_ready_i both high. While ready is low, the address, index and strobe hold.
- R5: Registers are visited in ascending index order, each selected one exactly once, with reg_idx_o giving the index. mem_we_o is 1 on every request of a store (is_load_i=0) and 0 for a load.
- R6: Bits [1:0] of mem_addr_o are always 0 while a request is presented.
- R7: In the cycle after the last word is accepted, done_o is high for exactly one cycle, and busy_o returns to 0 the cycle after that. final_base_o then equals base+4n for modes 0/1 and base-4n for modes 2/3.
- R8: base_we_o is high together with done_o exactly when the base-update flag was set at start and the bitmap was not empty. It is low otherwise.
- R9: An empty bitmap produces done_o in the cycle after start, with no request and base_we_o low.
- R10: A start strobe while busy_o is high is ignored and does not disturb the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| base_i | input | 32 | Base address |
| reg_list_i | input | 16 | Register-select bitmap |
| mode_i | input | 2 | 0 climb-after, 1 climb-before, 2 fall-after, 3 fall-before |
| is_load_i | input | 1 | 1 = load, 0 = store |
| wb_en_i | input | 1 | Request base update at the end |
| mem_ready_i | input | 1 | Memory accepts the current word |
| mem_req_o | output | 1 | Word transfer requested |
| mem_we_o | output | 1 | Word transfer is a write |
| mem_addr_o | output | 32 | Word address |
| reg_idx_o | output | 4 | Register index of the current word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| final_base_o | output | 32 | Updated base value, valid with done_o |
| base_we_o | output | 1 | Write enable for the updated base |

## Verification
The bench targets several corner cases, each tied to the error it would expose:
- The fall-before and fall-after offsets with the full sixteen-register list. A wrong multiple of four there shifts every address.
- A base of 0xFFFFFFFC, to show that wrap-around stays modular.
- An unaligned base, to catch low address bits that leak out.
- A single register at index 15, to catch a one-off error in the "last" detection, which would end early or run an extra word.
- Random ready stalls combined with start strobes issued mid-sequence. These expose a sequencer that advances without ready or restarts on a stray strobe.
- An empty list. A design that mishandles it hangs or issues a phantom transfer.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    AM_CLIMB_AFTER  = 2'd0,
    AM_CLIMB_BEFORE = 2'd1,
    AM_FALL_AFTER   = 2'd2,
    AM_FALL_BEFORE  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int unsigned N  = 16,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  function automatic logic [CW-1:0] count_bits(input logic [N-1:0] v);
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < int'(N); i++) acc = acc + CW'(v[i]);
    return acc;
  endfunction

  assign cnt_o = count_bits(vec_i);
endmodule

// File: rtl/lsm_pick_low.sv
module lsm_pick_low #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o,
  output logic          last_o
);
  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = int'(N) - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  assign idx_o  = lowest_set(vec_i);
  assign any_o  = |vec_i;
  assign last_o = ($countones(vec_i) == 1);
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
  import lsm_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 5
) (
  input  logic [AW-1:0] base_i,
  input  amode_e        mode_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] first_addr_o,
  output logic [AW-1:0] end_base_o
);
  function automatic logic [AW-1:0] span_of(input logic [CW-1:0] n);
    return AW'(n) * AW'(WORD_BYTES);
  endfunction

  function automatic logic [AW-1:0] first_of(input logic [AW-1:0] b, input amode_e m,
                                             input logic [CW-1:0] n);
    case (m)
      AM_CLIMB_AFTER:  return b;
      AM_CLIMB_BEFORE: return b + AW'(WORD_BYTES);
      AM_FALL_AFTER:   return b - span_of(n) + AW'(WORD_BYTES);
      default:         return b - span_of(n);
    endcase
  endfunction

  function automatic logic [AW-1:0] end_of(input logic [AW-1:0] b, input amode_e m,
                                           input logic [CW-1:0] n);
    return m[1] ? (b - span_of(n)) : (b + span_of(n));
  endfunction

  assign first_addr_o = first_of(base_i, mode_i, cnt_i) & ~AW'(WORD_BYTES - 1);
  assign end_base_o   = end_of(base_i, mode_i, cnt_i);
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] reg_list_i,
  input  logic [1:0]      mode_i,
  input  logic            is_load_i,
  input  logic            wb_en_i,
  input  logic            mem_ready_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [IW-1:0]   reg_idx_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [AW-1:0]   final_base_o,
  output logic            base_we_o
);
  seq_state_e      state_q;
  logic [NREG-1:0] mask_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   end_base_q;
  logic            store_q;
  logic            wb_q;

  logic [CW-1:0]   list_cnt;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   end_base;
  logic [IW-1:0]   cur_idx;
  logic            mask_any;
  logic            mask_last;

  // named internal events
  logic seq_accept;
  logic list_empty;
  logic xfer_fire;
  logic xfer_final;

  lsm_popcount #(.N(NREG), .CW(CW)) u_cnt (
    .vec_i(reg_list_i), .cnt_o(list_cnt)
  );

  lsm_addr_plan #(.AW(AW), .CW(CW)) u_plan (
    .base_i(base_i), .mode_i(amode_e'(mode_i)), .cnt_i(list_cnt),
    .first_addr_o(first_addr), .end_base_o(end_base)
  );

  lsm_pick_low #(.N(NREG), .IW(IW)) u_pick (
    .vec_i(mask_q), .idx_o(cur_idx), .any_o(mask_any), .last_o(mask_last)
  );

  assign seq_accept = start_i && (state_q == ST_IDLE);
  assign list_empty = (list_cnt == '0);
  assign xfer_fire  = (state_q == ST_XFER) && mem_ready_i && mask_any;
  assign xfer_final = xfer_fire && mask_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mask_q     <= '0;
      addr_q     <= '0;
      end_base_q <= '0;
      store_q    <= 1'b0;
      wb_q       <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (seq_accept) begin
          mask_q     <= reg_list_i;
          addr_q     <= first_addr;
          end_base_q <= end_base;
          store_q    <= !is_load_i;
          wb_q       <= wb_en_i && !list_empty;
          state_q    <= list_empty ? ST_DONE : ST_XFER;
        end
        ST_XFER: if (xfer_fire) begin
          mask_q[cur_idx] <= 1'b0;
          addr_q          <= addr_q + AW'(WORD_BYTES);
          if (xfer_final) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o    = (state_q == ST_XFER);
  assign mem_we_o     = mem_req_o && store_q;
  assign mem_addr_o   = addr_q;
  assign reg_idx_o    = cur_idx;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign final_base_o = end_base_q;
  assign base_we_o    = done_o && wb_q;

  // R4: a stalled request holds everything
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(reg_idx_o)
                                  && $stable(mem_we_o));
  // R3: accepted non-final word steps the address by one word
  a_r3_step_four: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire && !xfer_final |=> mem_addr_o == $past(mem_addr_o) + AW'(WORD_BYTES));
  // R5: register indices climb strictly
  a_r5_idx_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire && !xfer_final |=> mem_req_o && (reg_idx_o > $past(reg_idx_o)));
  // R6: word alignment of issued addresses
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
  // R7: done is a single-cycle pulse following the final word
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_final |=> done_o && !mem_req_o);
  // R9: empty list completes immediately with no writeback
  a_r9_empty_list: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept && list_empty |=> done_o && !mem_req_o && !base_we_o);
  // R10: a strobe during a stalled transfer changes nothing
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));
  // R8: base write only alongside done
  a_r8_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    base_we_o |-> done_o);
endmodule

// File: tb/sim_lsm_addr_seq.sv
`timescale 1ns/1ps
module sim_lsm_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reg_list_i = '0;
  logic [1:0]  mode_i = '0;
  logic        is_load_i = 1'b0;
  logic        wb_en_i = 1'b0;
  logic        mem_ready_i = 1'b0;
  logic        mem_req_o, mem_we_o, busy_o, done_o, base_we_o;
  logic [31:0] mem_addr_o, final_base_o;
  logic [3:0]  reg_idx_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lsm_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .reg_list_i(reg_list_i), .mode_i(mode_i), .is_load_i(is_load_i),
    .wb_en_i(wb_en_i), .mem_ready_i(mem_ready_i), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .reg_idx_o(reg_idx_o),
    .busy_o(busy_o), .done_o(done_o), .final_base_o(final_base_o),
    .base_we_o(base_we_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic int n_of(input logic [15:0] l);
    int c = 0;
    for (int i = 0; i < 16; i++) if (l[i]) c++;
    return c;
  endfunction

  function automatic int kth_reg(input logic [15:0] l, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++)
      if (l[i]) begin
        if (seen == k) return i;
        seen++;
      end
    return -1;
  endfunction

  // lowest word address touched by the sequence
  function automatic logic [31:0] low_addr(input logic [31:0] b, input logic [1:0] m, input int n);
    logic [31:0] sz = 32'(4 * n);
    if (m == 2'd0) return b;
    if (m == 2'd1) return b + 32'd4;
    if (m == 2'd2) return b - sz + 32'd4;
    return b - sz;
  endfunction

  function automatic logic [31:0] new_base(input logic [31:0] b, input logic [1:0] m, input int n);
    return m[1] ? b - 32'(4 * n) : b + 32'(4 * n);
  endfunction

  task automatic run_seq(input logic [31:0] b, input logic [15:0] l, input logic [1:0] m,
                         input bit ld, input bit wb);
    int n = n_of(l);
    int k = 0;
    int guard = 0;
    bit prev_stall = 0;
    logic [31:0] prev_addr = '0;
    logic [31:0] start_a = low_addr(b, m, n) & 32'hFFFF_FFFC;
    @(negedge clk);
    base_i = b; reg_list_i = l; mode_i = m; is_load_i = ld; wb_en_i = wb;
    start_i = 1'b1; mem_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    forever begin
      if (done_o) begin
        start_i = 1'b0; mem_ready_i = 1'b0;
        chk(k == n, "R7 word count at done", 32'(k), 32'(n));
        chk(final_base_o == new_base(b, m, n), "R7 final base", final_base_o, new_base(b, m, n));
        if (n == 0)
          chk(base_we_o == 1'b0, "R9 empty list base_we", 32'(base_we_o), 0);
        else
          chk(base_we_o == wb, "R8 base write enable", 32'(base_we_o), 32'(wb));
        chk(mem_req_o == 1'b0, "R7 no request at done", 32'(mem_req_o), 0);
        break;
      end
      if (n == 0) chk(1'b0, "R9 empty list must finish at once", 32'(mem_req_o), 0);
      chk(mem_req_o == 1'b1, "R5 request while words remain", 32'(mem_req_o), 1);
      if (k == 0) chk(mem_addr_o == start_a, "R2 first address", mem_addr_o, start_a);
      else chk(mem_addr_o == start_a + 32'(4 * k), "R3 address step", mem_addr_o,
               start_a + 32'(4 * k));
      if (prev_stall) chk(mem_addr_o == prev_addr, "R4 hold on stall", mem_addr_o, prev_addr);
      chk(mem_addr_o[1:0] == 2'b00, "R6 aligned", mem_addr_o, mem_addr_o & 32'hFFFF_FFFC);
      chk(32'(reg_idx_o) == 32'(kth_reg(l, k)), "R5 register order", 32'(reg_idx_o),
          32'(kth_reg(l, k)));
      chk(mem_we_o == !ld, "R5 write strobe", 32'(mem_we_o), 32'(!ld));
      prev_addr = mem_addr_o;
      mem_ready_i = ($urandom_range(0, 9) < 7);
      prev_stall = !mem_ready_i;
      // R10: stray strobes with unrelated request data while busy
      start_i = ($urandom_range(0, 3) == 0);
      if (start_i) begin
        base_i = $urandom(); reg_list_i = 16'($urandom()); mode_i = 2'($urandom());
        is_load_i = ~ld;
      end
      @(negedge clk);
      if (mem_ready_i) k++;
      guard++;
      if (guard > 500) begin
        chk(1'b0, "R4 sequence did not finish", 32'(k), 32'(n));
        break;
      end
    end
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R7 done one cycle then idle",
        {30'd0, done_o, busy_o}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk(busy_o == 0 && mem_req_o == 0 && done_o == 0 && base_we_o == 0, "R1 reset state",
        {28'd0, busy_o, mem_req_o, done_o, base_we_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(busy_o == 0 && mem_req_o == 0, "R1 idle after reset", {30'd0, busy_o, mem_req_o}, 0);
    // directed corners
    run_seq(32'h0000_1000, 16'h0000, 2'd0, 1'b1, 1'b1);  // R9 empty
    run_seq(32'h0000_2000, 16'hFFFF, 2'd3, 1'b0, 1'b1);  // full list, fall-before
    run_seq(32'h0000_2000, 16'hFFFF, 2'd2, 1'b1, 1'b1);  // fall-after
    run_seq(32'h0000_3000, 16'h8000, 2'd1, 1'b1, 1'b0);  // single top register
    run_seq(32'hFFFF_FFFC, 16'h0013, 2'd0, 1'b0, 1'b1);  // wrap-around
    run_seq(32'h0000_1003, 16'h0421, 2'd1, 1'b1, 1'b1);  // unaligned base, R6
    run_seq(32'h0000_0008, 16'h0007, 2'd3, 1'b1, 1'b1);  // below zero wrap
    for (int t = 0; t < 300; t++) begin
      logic [15:0] l;
      int sel = $urandom_range(0, 9);
      if (sel == 0) l = '0;
      else if (sel == 1) l = 16'(1) << $urandom_range(0, 15);
      else l = 16'($urandom());
      run_seq($urandom(), l, 2'($urandom()), 1'($urandom()), 1'($urandom()));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule